// File: doc/BRIEF.md
# Graphics Function Configuration Register Target

This block is the configuration-space register file of a PCI graphics function. A bus front end, which is not part of the block, hands it one access at a time: a byte offset, a direction flag and a 32-bit data word. The block answers each access with a one-cycle acknowledge and, for reads, the selected register value.

The block holds a constant identity word and a two-bit command register. It also holds a memory base-address register that answers the standard all-ones size probe with a fixed 16 MB mask. A fourth register, the init-enable word, is readable and writable. Its value drives an output bus toward the function's core, and every write to it comes with a one-cycle strobe. From the command register and the base address the block computes a memory-decode hit for the core.

Access sequencing is done by a small state machine:
- **ST_IDLE** accepts a request. It goes to ST_READ when the write flag is low and to ST_WRITE when the write flag is high.
- **ST_READ** presents read data with the acknowledge. It always returns to ST_IDLE.
- **ST_WRITE** commits the write with the acknowledge. It always returns to ST_IDLE.

Top module: `cfgt_target`

## Requirements
- R1: After reset, the command, base-address and init-enable registers are 0, and `cfg_ack`, `cfg_rdata`, `init_strobe` and `mem_hit` are all low.
- R2: A read of offset 0x00 returns 0x0001121A.
- R3: A write to offset 0x04 stores only data bits [1:0]. A later read of 0x04 returns those two bits with all upper bits 0.
- R4: Writing 0xFFFFFFFF to offset 0x10 makes a later read of 0x10 return 0xFF000000.
- R5: Writing any other value to offset 0x10 stores it unchanged, and a later read of 0x10 returns it.
- R6: Offset 0x40 is read/write. After a write there, `init_enable` carries the written word from the cycle after the acknowledge onward, and it is stable otherwise.
- R7: `init_strobe` is high for exactly one cycle, the cycle after the acknowledge of a write to 0x40. It stays low for all other accesses.
- R8: Reads of any other offset return 0. Writes to any other offset leave all registers and `init_enable` unchanged.
- R9: A request seen in ST_IDLE is acknowledged in the next cycle for exactly one cycle. A request held high is accepted every other cycle. `cfg_rdata` is 0 whenever `cfg_ack` is low.
- R10: `mem_hit` is high exactly when command bit 1 is set and `mem_addr[31:24]` equals base-address bits [31:24].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_req | input | 1 | Access request, taken in ST_IDLE |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_off | input | 8 | Byte offset of the register |
| cfg_wdata | input | 32 | Write data |
| cfg_ack | output | 1 | One-cycle access acknowledge |
| cfg_rdata | output | 32 | Read data, valid with the acknowledge |
| init_enable | output | 32 | Init-enable word driven to the core |
| init_strobe | output | 1 | One-cycle pulse after each init-enable write |
| mem_addr | input | 32 | Memory address presented for decode |
| mem_hit | output | 1 | Memory decode hit |

## Verification
The bench builds the block with its default parameters: a 32-bit data path, 8-bit offsets, an 8-bit decode field and the 16 MB size mask. These values make every implemented offset and many unimplemented offsets reachable with random byte offsets. Base addresses are drawn at random, and decode addresses are often taken from the stored base, so both hits and misses occur across the full upper-byte compare. The all-ones size probe, held requests and command bit 1 toggling are covered by directed cases.

// File: rtl/cfgt_pkg.sv
`timescale 1ns/1ps
package cfgt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } cfgt_state_e;
endpackage

// File: rtl/cfgt_fsm.sv
`timescale 1ns/1ps
module cfgt_fsm
    import cfgt_pkg::*;
#(
    parameter int OFF_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] wdata,
    output logic [OFF_W-1:0]  lat_off,
    output logic [DATA_W-1:0] lat_data,
    output logic              ack,
    output logic              rd_active,
    output logic              wr_commit
);
    cfgt_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // request capture, only when a request is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_off  <= '0;
            lat_data <= '0;
        end else if (state_q == ST_IDLE && req) begin
            lat_off  <= off;
            lat_data <= wdata;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req) state_d = we ? ST_WRITE : ST_READ;
            ST_READ:  state_d = ST_IDLE;
            ST_WRITE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ack       = 1'b0;
        rd_active = 1'b0;
        wr_commit = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_READ:  begin ack = 1'b1; rd_active = 1'b1; end
            ST_WRITE: begin ack = 1'b1; wr_commit = 1'b1; end
            default:  ;
        endcase
    end
endmodule

// File: rtl/cfgt_regs.sv
`timescale 1ns/1ps
module cfgt_regs #(
    parameter int               OFF_W     = 8,
    parameter int               DATA_W    = 32,
    parameter int               CMD_W     = 2,
    parameter logic [DATA_W-1:0] ID_WORD   = 32'h0001121A,
    parameter logic [DATA_W-1:0] SIZE_MASK = 32'hFF000000,
    parameter logic [OFF_W-1:0] OFF_ID    = 8'h00,
    parameter logic [OFF_W-1:0] OFF_CMD   = 8'h04,
    parameter logic [OFF_W-1:0] OFF_BAR   = 8'h10,
    parameter logic [OFF_W-1:0] OFF_INIT  = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFF_W-1:0]  lat_off,
    input  logic [DATA_W-1:0] lat_data,
    input  logic              rd_active,
    input  logic              wr_commit,
    output logic [DATA_W-1:0] rdata,
    output logic [CMD_W-1:0]  cmd_q,
    output logic [DATA_W-1:0] bar_q,
    output logic [DATA_W-1:0] init_q,
    output logic              strobe_q
);
    localparam logic [DATA_W-1:0] PROBE = {DATA_W{1'b1}};

    logic sel_cmd, sel_bar, sel_init, sel_id;
    assign sel_id   = (lat_off == OFF_ID);
    assign sel_cmd  = (lat_off == OFF_CMD);
    assign sel_bar  = (lat_off == OFF_BAR);
    assign sel_init = (lat_off == OFF_INIT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q    <= '0;
            bar_q    <= '0;
            init_q   <= '0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= wr_commit && sel_init;
            if (wr_commit) begin
                if (sel_cmd) begin
                    cmd_q <= lat_data[CMD_W-1:0];
                end
                if (sel_bar) begin
                    bar_q <= (lat_data == PROBE) ? SIZE_MASK : lat_data;
                end
                if (sel_init) begin
                    init_q <= lat_data;
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_active) begin
            if (sel_id)        rdata = ID_WORD;
            else if (sel_cmd)  rdata = {{(DATA_W-CMD_W){1'b0}}, cmd_q};
            else if (sel_bar)  rdata = bar_q;
            else if (sel_init) rdata = init_q;
        end
    end
endmodule

// File: rtl/cfgt_decode.sv
`timescale 1ns/1ps
module cfgt_decode #(
    parameter int DATA_W   = 32,
    parameter int CMD_W    = 2,
    parameter int DEC_BITS = 8,
    parameter int ENA_BIT  = 1
) (
    input  logic [CMD_W-1:0]  cmd,
    input  logic [DATA_W-1:0] bar,
    input  logic [DATA_W-1:0] addr,
    output logic              hit
);
    localparam int TOP = DATA_W - 1;

    logic field_eq;
    assign field_eq = (addr[TOP -: DEC_BITS] == bar[TOP -: DEC_BITS]);
    assign hit      = cmd[ENA_BIT] && field_eq;
endmodule

// File: rtl/cfgt_target.sv
`timescale 1ns/1ps
module cfgt_target #(
    parameter int OFF_W    = 8,
    parameter int DATA_W   = 32,
    parameter int DEC_BITS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_req,
    input  logic              cfg_we,
    input  logic [OFF_W-1:0]  cfg_off,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              cfg_ack,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic [DATA_W-1:0] init_enable,
    output logic              init_strobe,
    input  logic [DATA_W-1:0] mem_addr,
    output logic              mem_hit
);
    localparam int CMD_W = 2;
    localparam logic [DATA_W-1:0] SIZE_MASK =
        {{DEC_BITS{1'b1}}, {(DATA_W-DEC_BITS){1'b0}}};

    logic [OFF_W-1:0]  lat_off;
    logic [DATA_W-1:0] lat_data;
    logic              rd_active, wr_commit;
    logic [CMD_W-1:0]  cmd_q;
    logic [DATA_W-1:0] bar_q;

    cfgt_fsm #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (cfg_req),
        .we        (cfg_we),
        .off       (cfg_off),
        .wdata     (cfg_wdata),
        .lat_off   (lat_off),
        .lat_data  (lat_data),
        .ack       (cfg_ack),
        .rd_active (rd_active),
        .wr_commit (wr_commit)
    );

    cfgt_regs #(
        .OFF_W     (OFF_W),
        .DATA_W    (DATA_W),
        .CMD_W     (CMD_W),
        .SIZE_MASK (SIZE_MASK)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .lat_off   (lat_off),
        .lat_data  (lat_data),
        .rd_active (rd_active),
        .wr_commit (wr_commit),
        .rdata     (cfg_rdata),
        .cmd_q     (cmd_q),
        .bar_q     (bar_q),
        .init_q    (init_enable),
        .strobe_q  (init_strobe)
    );

    cfgt_decode #(
        .DATA_W   (DATA_W),
        .CMD_W    (CMD_W),
        .DEC_BITS (DEC_BITS),
        .ENA_BIT  (1)
    ) u_dec (
        .cmd  (cmd_q),
        .bar  (bar_q),
        .addr (mem_addr),
        .hit  (mem_hit)
    );
endmodule

// File: rtl/cfgt_target_chk.sv
`timescale 1ns/1ps
module cfgt_target_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack,
    input logic [DATA_W-1:0] rdata,
    input logic [DATA_W-1:0] init_en,
    input logic              strobe,
    input logic [1:0]        cmd,
    input logic              hit
);
    assert_ack_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    assert_rdata_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |-> (rdata == '0));

    assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

    assert_strobe_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> $past(ack));

    assert_init_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |-> $stable(init_en));

    assert_hit_needs_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd[1] |-> !hit);
endmodule

bind cfgt_target cfgt_target_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ack     (cfg_ack),
    .rdata   (cfg_rdata),
    .init_en (init_enable),
    .strobe  (init_strobe),
    .cmd     (cmd_q),
    .hit     (mem_hit)
);

// File: tb/cfgt_target_test.sv
`timescale 1ns/1ps
module cfgt_target_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_req = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_off = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_ack;
    logic [31:0] cfg_rdata;
    logic [31:0] init_enable;
    logic        init_strobe;
    logic [31:0] mem_addr = '0;
    logic        mem_hit;

    int total = 0;
    int bad = 0;

    logic [1:0]  cmd_m = '0;
    logic [31:0] bar_m = '0;
    logic [31:0] init_m = '0;

    always #2.5 clk = ~clk;

    cfgt_target uut (
        .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_we(cfg_we),
        .cfg_off(cfg_off), .cfg_wdata(cfg_wdata), .cfg_ack(cfg_ack),
        .cfg_rdata(cfg_rdata), .init_enable(init_enable),
        .init_strobe(init_strobe), .mem_addr(mem_addr), .mem_hit(mem_hit)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [7:0] off);
        case (off)
            8'h00:   return 32'h0001121A;
            8'h04:   return {30'd0, cmd_m};
            8'h10:   return bar_m;
            8'h40:   return init_m;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic exp_hit(input logic [31:0] a);
        return cmd_m[1] && (a[31:24] == bar_m[31:24]);
    endfunction

    task automatic do_write(input logic [7:0] off, input logic [31:0] d);
        @(negedge clk);
        cfg_req = 1'b1; cfg_we = 1'b1; cfg_off = off; cfg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        check(cfg_ack == 1'b1, "R9 write ack", {31'd0, cfg_ack}, 32'd1);
        cfg_req = 1'b0; cfg_we = 1'b0;
        case (off)
            8'h04: cmd_m = d[1:0];
            8'h10: bar_m = (d == 32'hFFFFFFFF) ? 32'hFF000000 : d;
            8'h40: init_m = d;
            default: ;
        endcase
        @(posedge clk);
        @(negedge clk);
        check(init_strobe == (off == 8'h40), "R7 strobe",
              {31'd0, init_strobe}, {31'd0, off == 8'h40});
        check(init_enable == init_m, (off == 8'h40) ? "R6 init out" : "R8 init out kept",
              init_enable, init_m);
    endtask

    task automatic do_read(input logic [7:0] off, input string req);
        logic [31:0] e;
        @(negedge clk);
        cfg_req = 1'b1; cfg_we = 1'b0; cfg_off = off;
        @(posedge clk);
        @(negedge clk);
        e = exp_read(off);
        check(cfg_ack == 1'b1, "R9 read ack", {31'd0, cfg_ack}, 32'd1);
        check(cfg_rdata == e, req, cfg_rdata, e);
        cfg_req = 1'b0;
    endtask

    task automatic check_hit(input logic [31:0] a);
        @(negedge clk);
        mem_addr = a;
        #1;
        check(mem_hit == exp_hit(a), "R10 mem_hit", {31'd0, mem_hit}, {31'd0, exp_hit(a)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0]  off;
        logic [31:0] d;
        logic [31:0] a;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cfg_ack == 1'b0, "R1 ack", {31'd0, cfg_ack}, 0);
        check(cfg_rdata == 0, "R1 rdata", cfg_rdata, 0);
        check(init_enable == 0, "R1 init", init_enable, 0);
        check(init_strobe == 0, "R1 strobe", {31'd0, init_strobe}, 0);
        check(mem_hit == 0, "R1 hit", {31'd0, mem_hit}, 0);
        do_read(8'h04, "R1 cmd reset");
        do_read(8'h10, "R1 bar reset");
        do_read(8'h40, "R1 init reset");

        // directed corners
        do_read(8'h00, "R2 identity");
        do_write(8'h04, 32'hFFFF_FFFE);
        do_read(8'h04, "R3 cmd masked");
        do_write(8'h10, 32'hFFFF_FFFF);
        do_read(8'h10, "R4 size probe");
        do_write(8'h10, 32'hFFFF_FFFE);
        do_read(8'h10, "R5 near all-ones kept");
        do_write(8'h10, 32'h1234_5678);
        do_read(8'h10, "R5 bar stored");
        check_hit(32'h12AB_CDEF);
        check_hit(32'h13AB_CDEF);
        do_write(8'h04, 32'h0000_0001);
        check_hit(32'h1200_0000);
        do_write(8'h40, 32'hA5A5_0F0F);
        do_read(8'h40, "R6 init readback");
        do_write(8'h44, 32'hDEAD_BEEF);
        do_read(8'h44, "R8 unimpl read");
        do_read(8'h04, "R8 cmd kept");
        do_read(8'h10, "R8 bar kept");
        do_read(8'h40, "R8 init kept");

        // R9 held request: accepted every other cycle
        @(negedge clk);
        cfg_req = 1'b1; cfg_we = 1'b0; cfg_off = 8'h00;
        for (int k = 0; k < 4; k++) begin
            @(posedge clk);
            @(negedge clk);
            check(cfg_ack == ((k % 2) == 0), "R9 held request ack",
                  {31'd0, cfg_ack}, {31'd0, (k % 2) == 0});
        end
        cfg_req = 1'b0;

        // constrained random mix
        for (int i = 0; i < 400; i++) begin
            case ($urandom_range(0, 5))
                0: off = 8'h00;
                1: off = 8'h04;
                2: off = 8'h10;
                3: off = 8'h40;
                default: begin
                    off = 8'($urandom_range(0, 255));
                    if (off == 8'h00 || off == 8'h04 || off == 8'h10 || off == 8'h40)
                        off = 8'h3C;
                end
            endcase
            d = ($urandom_range(0, 7) == 0) ? 32'hFFFF_FFFF : $urandom;
            if ($urandom_range(0, 1) == 1) begin
                do_write(off, d);
            end else begin
                do_read(off, (off == 8'h00) ? "R2 rand" :
                             (off == 8'h04) ? "R3 rand" :
                             (off == 8'h10) ? "R5 rand" :
                             (off == 8'h40) ? "R6 rand" : "R8 rand");
            end
            a = $urandom;
            if ($urandom_range(0, 1) == 1) a[31:24] = bar_m[31:24];
            check_hit(a);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule